// File: doc/BRIEF.md
# Operand and Effective Address Generator

This block builds the second ALU operand and every address that a processor's control sequence needs from one instruction. It takes the low field bits of the instruction word, the already incremented program counter, the base register value, the second source register value and a value from the shared bus or memory data. From these it produces three results. The first is the operand B for the ALU. The second is the candidate for the memory address register. The third is the next program counter value. It also returns the raw address adder sum, which is the value a load-effective-address instruction writes back to its destination register.

A single adder produces every computed address. Its base input is the incremented PC, the base register or zero. Its offset input is zero or one of three sign-extended instruction fields. The control unit drives the select lines for each phase. Each field is extended to the data width before the addition, and the sum wraps modulo 2^DW. When the parameter `REG_OUT` is 1 (the default), all results are registered and appear one clock after `in_valid`. When it is 0, the results are combinational.

Top module: `opnd_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `out_valid` is 0 and `alu_b`, `eff_addr`, `addr_sum` and `next_pc` are all zero.
- R2: With `in_valid` high at an edge, `out_valid` is 1 after that edge and the four results reflect the inputs sampled at that edge. With `in_valid` low, `out_valid` drops to 0 and all four results hold their previous values, whatever the other inputs do.
- R3: `alu_b` equals `sr2_val` when `ifield[5]` is 0. It equals `ifield[4:0]` sign-extended to DW bits when `ifield[5]` is 1.
- R4: The adder offset is chosen by `ofs_sel`: 0 selects zero, 1 selects `ifield[5:0]` sign-extended, 2 selects `ifield[8:0]` sign-extended (reach −256..+255), and 3 selects `ifield[10:0]` sign-extended.
- R5: The adder base is chosen by `base_sel`: 0 selects `pc_inc`, 1 selects `base_val`, and 2 or 3 selects zero.
- R6: `addr_sum` is base plus offset modulo 2^DW. A sum that crosses the top or the bottom of the address space wraps around.
- R7: `eff_addr` is chosen by `mar_sel`: 0 or 3 selects `addr_sum`, 1 selects `ifield[7:0]` zero-extended, and 2 selects `bus_val` (the indirect step).
- R8: `next_pc` is chosen by `pc_sel`: 0 or 3 selects `pc_inc`, 1 selects `addr_sum`, and 2 selects `bus_val`.
- R9: A register jump (`base_sel`=1, `ofs_sel`=0, `pc_sel`=1) makes `next_pc` equal to `base_val` for any 16-bit value, including 0x0000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| ifield | input | 11 | Instruction bits [10:0] |
| pc_inc | input | DW | Incremented program counter |
| base_val | input | DW | Base register read value |
| sr2_val | input | DW | Second source register read value |
| bus_val | input | DW | Bus or memory data value for the indirect step |
| base_sel | input | 2 | Adder base select |
| ofs_sel | input | 2 | Adder offset select |
| mar_sel | input | 2 | Address register source select |
| pc_sel | input | 2 | Next-PC source select |
| out_valid | output | 1 | Results are valid |
| alu_b | output | DW | ALU operand B |
| eff_addr | output | DW | Memory address register input |
| addr_sum | output | DW | Address adder result (load-effective-address value) |
| next_pc | output | DW | Next program counter candidate |

## Verification
Wraparound of the adder is the hardest case to reach, because it needs a carry or borrow out of the top bit. The stimulus pairs `pc_inc` = 0xFFFF with a positive offset, and a zero base register with a negative 6-bit offset. It also uses the extreme 9-bit offsets 0x0FF and 0x100 against a mid-range PC. The hold behaviour is shown by idle cycles in which every data and select input is changed to unrelated values. The outputs are then compared with the last expected result.

// File: rtl/oag_pkg.sv
package oag_pkg;
  localparam int IMM_W  = 5;
  localparam int OFS_SW = 6;
  localparam int OFS_MW = 9;
  localparam int OFS_LW = 11;
  localparam int VEC_W  = 8;
  localparam int FLD_W  = 11;
  localparam int MODE_BIT = 5;

  typedef enum logic [1:0] {
    BASE_PC   = 2'd0,
    BASE_REG  = 2'd1,
    BASE_NIL  = 2'd2,
    BASE_NIL2 = 2'd3
  } base_src_e;

  typedef enum logic [1:0] {
    OFS_NONE  = 2'd0,
    OFS_SHORT = 2'd1,
    OFS_MID   = 2'd2,
    OFS_LONG  = 2'd3
  } ofs_src_e;

  typedef enum logic [1:0] {
    MA_SUM  = 2'd0,
    MA_VEC  = 2'd1,
    MA_BUS  = 2'd2,
    MA_SUM2 = 2'd3
  } mar_src_e;

  typedef enum logic [1:0] {
    NP_SEQ  = 2'd0,
    NP_SUM  = 2'd1,
    NP_BUS  = 2'd2,
    NP_SEQ2 = 2'd3
  } npc_src_e;
endpackage

// File: rtl/oag_ext_fields.sv
module oag_ext_fields
  import oag_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [FLD_W-1:0] ifield,
  output logic [DW-1:0]    imm_x,
  output logic [DW-1:0]    ofs_s_x,
  output logic [DW-1:0]    ofs_m_x,
  output logic [DW-1:0]    ofs_l_x,
  output logic [DW-1:0]    vec_z
);
  localparam int NOFS = 4;
  localparam int FW [NOFS] = '{IMM_W, OFS_SW, OFS_MW, OFS_LW};

  logic [DW-1:0] ext [NOFS];

  for (genvar g = 0; g < NOFS; g++) begin : g_sext
    assign ext[g] = {{(DW-FW[g]){ifield[FW[g]-1]}}, ifield[FW[g]-1:0]};
  end

  assign imm_x   = ext[0];
  assign ofs_s_x = ext[1];
  assign ofs_m_x = ext[2];
  assign ofs_l_x = ext[3];
  assign vec_z   = {{(DW-VEC_W){1'b0}}, ifield[VEC_W-1:0]};
endmodule

// File: rtl/oag_addr_adder.sv
module oag_addr_adder
  import oag_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]    base_sel,
  input  logic [1:0]    ofs_sel,
  input  logic [DW-1:0] pc_inc,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] ofs_s_x,
  input  logic [DW-1:0] ofs_m_x,
  input  logic [DW-1:0] ofs_l_x,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] base_op;
  logic [DW-1:0] ofs_op;

  always_comb begin
    unique case (base_src_e'(base_sel))
      BASE_PC:  base_op = pc_inc;
      BASE_REG: base_op = base_val;
      default:  base_op = '0;
    endcase
  end

  always_comb begin
    unique case (ofs_src_e'(ofs_sel))
      OFS_SHORT: ofs_op = ofs_s_x;
      OFS_MID:   ofs_op = ofs_m_x;
      OFS_LONG:  ofs_op = ofs_l_x;
      default:   ofs_op = '0;
    endcase
  end

  // single shared adder, carry out discarded so the result wraps
  assign sum = base_op + ofs_op;
endmodule

// File: rtl/oag_out_mux.sv
module oag_out_mux
  import oag_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          imm_mode,
  input  logic [1:0]    mar_sel,
  input  logic [1:0]    pc_sel,
  input  logic [DW-1:0] imm_x,
  input  logic [DW-1:0] sr2_val,
  input  logic [DW-1:0] vec_z,
  input  logic [DW-1:0] sum,
  input  logic [DW-1:0] pc_inc,
  input  logic [DW-1:0] bus_val,
  output logic [DW-1:0] alu_b,
  output logic [DW-1:0] eff_addr,
  output logic [DW-1:0] next_pc
);
  assign alu_b = imm_mode ? imm_x : sr2_val;

  always_comb begin
    unique case (mar_src_e'(mar_sel))
      MA_VEC:  eff_addr = vec_z;
      MA_BUS:  eff_addr = bus_val;
      default: eff_addr = sum;
    endcase
  end

  always_comb begin
    unique case (npc_src_e'(pc_sel))
      NP_SUM:  next_pc = sum;
      NP_BUS:  next_pc = bus_val;
      default: next_pc = pc_inc;
    endcase
  end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import oag_pkg::*;
#(
  parameter int DW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [FLD_W-1:0] ifield,
  input  logic [DW-1:0]    pc_inc,
  input  logic [DW-1:0]    base_val,
  input  logic [DW-1:0]    sr2_val,
  input  logic [DW-1:0]    bus_val,
  input  logic [1:0]       base_sel,
  input  logic [1:0]       ofs_sel,
  input  logic [1:0]       mar_sel,
  input  logic [1:0]       pc_sel,
  output logic             out_valid,
  output logic [DW-1:0]    alu_b,
  output logic [DW-1:0]    eff_addr,
  output logic [DW-1:0]    addr_sum,
  output logic [DW-1:0]    next_pc
);
  logic [DW-1:0] imm_x, ofs_s_x, ofs_m_x, ofs_l_x, vec_z;
  logic [DW-1:0] sum_c, alu_b_c, eff_c, npc_c;

  oag_ext_fields #(.DW(DW)) u_ext (
    .ifield (ifield),
    .imm_x  (imm_x),
    .ofs_s_x(ofs_s_x),
    .ofs_m_x(ofs_m_x),
    .ofs_l_x(ofs_l_x),
    .vec_z  (vec_z)
  );

  oag_addr_adder #(.DW(DW)) u_add (
    .base_sel(base_sel),
    .ofs_sel (ofs_sel),
    .pc_inc  (pc_inc),
    .base_val(base_val),
    .ofs_s_x (ofs_s_x),
    .ofs_m_x (ofs_m_x),
    .ofs_l_x (ofs_l_x),
    .sum     (sum_c)
  );

  oag_out_mux #(.DW(DW)) u_mux (
    .imm_mode(ifield[MODE_BIT]),
    .mar_sel (mar_sel),
    .pc_sel  (pc_sel),
    .imm_x   (imm_x),
    .sr2_val (sr2_val),
    .vec_z   (vec_z),
    .sum     (sum_c),
    .pc_inc  (pc_inc),
    .bus_val (bus_val),
    .alu_b   (alu_b_c),
    .eff_addr(eff_c),
    .next_pc (npc_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        alu_b     <= '0;
        eff_addr  <= '0;
        addr_sum  <= '0;
        next_pc   <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          alu_b    <= alu_b_c;
          eff_addr <= eff_c;
          addr_sum <= sum_c;
          next_pc  <= npc_c;
        end
      end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!out_valid && addr_sum == '0 && next_pc == '0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(alu_b) && $stable(eff_addr)
                     && $stable(addr_sum) && $stable(next_pc))); // R2
    AST_REG_OPERAND: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ifield[MODE_BIT]) |=> alu_b == $past(sr2_val)); // R3
    AST_IMM_SIGN: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ifield[MODE_BIT]) |=>
        ($countones(alu_b[DW-1:IMM_W-1]) == 0 ||
         $countones(alu_b[DW-1:IMM_W-1]) == DW-IMM_W+1)); // R3
    AST_ZERO_SUM: assert property (@(posedge clk) disable iff (rst)
      (in_valid && base_sel[1] && ofs_sel == 2'd0) |=> addr_sum == '0); // R5
    AST_VEC_ZEXT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mar_sel == 2'd1) |=>
        eff_addr == {{(DW-VEC_W){1'b0}}, $past(ifield[VEC_W-1:0])}); // R7
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (pc_sel == 2'd0 || pc_sel == 2'd3)) |=>
        next_pc == $past(pc_inc)); // R8
    AST_JUMP_REG: assert property (@(posedge clk) disable iff (rst)
      (in_valid && base_sel == 2'd1 && ofs_sel == 2'd0 && pc_sel == 2'd1) |=>
        next_pc == $past(base_val)); // R9
  end else begin : g_comb
    assign out_valid = in_valid;
    assign alu_b     = alu_b_c;
    assign eff_addr  = eff_c;
    assign addr_sum  = sum_c;
    assign next_pc   = npc_c;

    always_comb begin
      if (in_valid && base_sel == 2'd1 && ofs_sel == 2'd0 && pc_sel == 2'd1)
        AST_JUMP_COMB: assert (next_pc == base_val); // R9
    end
  end
endmodule

// File: tb/opnd_addr_gen_bench.sv
`timescale 1ns/1ps
module opnd_addr_gen_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [10:0]   ifield;
  logic [DW-1:0] pc_inc, base_val, sr2_val, bus_val;
  logic [1:0]    base_sel, ofs_sel, mar_sel, pc_sel;
  logic          out_valid;
  logic [DW-1:0] alu_b, eff_addr, addr_sum, next_pc;

  always #4 clk = ~clk;

  opnd_addr_gen #(.DW(DW), .REG_OUT(1'b1)) u_opnd_addr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ifield(ifield),
    .pc_inc(pc_inc), .base_val(base_val), .sr2_val(sr2_val), .bus_val(bus_val),
    .base_sel(base_sel), .ofs_sel(ofs_sel), .mar_sel(mar_sel), .pc_sel(pc_sel),
    .out_valid(out_valid), .alu_b(alu_b), .eff_addr(eff_addr),
    .addr_sum(addr_sum), .next_pc(next_pc)
  );

  typedef struct {
    logic [DW-1:0] b, ea, sum, npc;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] sx(input logic [10:0] f, input int w);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < DW; i++) r[i] = (i < w) ? f[i] : f[w-1];
    return r;
  endfunction

  function automatic exp_t model(input string tag);
    exp_t e;
    logic [DW-1:0] bs, of;
    e.tag = tag;
    e.b = ifield[5] ? sx(ifield, 5) : sr2_val;                  // R3
    case (ofs_sel)                                               // R4
      2'd0: of = '0;
      2'd1: of = sx(ifield, 6);
      2'd2: of = sx(ifield, 9);
      default: of = sx(ifield, 11);
    endcase
    case (base_sel)                                              // R5
      2'd0: bs = pc_inc;
      2'd1: bs = base_val;
      default: bs = '0;
    endcase
    e.sum = DW'((32'(bs) + 32'(of)) % 32'h10000);                // R6
    case (mar_sel)                                               // R7
      2'd1: e.ea = {8'h00, ifield[7:0]};
      2'd2: e.ea = bus_val;
      default: e.ea = e.sum;
    endcase
    case (pc_sel)                                                // R8
      2'd1: e.npc = e.sum;
      2'd2: e.npc = bus_val;
      default: e.npc = pc_inc;
    endcase
    return e;
  endfunction

  task automatic drive(input string tag, input logic [15:0] ir,
                       input logic [DW-1:0] pc, input logic [DW-1:0] bv,
                       input logic [DW-1:0] s2, input logic [DW-1:0] bus,
                       input logic [1:0] bsel, input logic [1:0] osel,
                       input logic [1:0] msel, input logic [1:0] psel);
    @(negedge clk);
    in_valid = 1'b1; ifield = ir[10:0]; pc_inc = pc; base_val = bv;
    sr2_val = s2; bus_val = bus; base_sel = bsel; ofs_sel = osel;
    mar_sel = msel; pc_sel = psel;
    exp_q.push_back(model(tag));
  endtask

  task automatic idle_scramble();
    @(negedge clk);
    in_valid = 1'b0; ifield = 11'h5A5; pc_inc = 16'h1357; base_val = 16'h2468;
    sr2_val = 16'h9ABC; bus_val = 16'hDEF0; base_sel = 2'd1; ofs_sel = 2'd3;
    mar_sel = 2'd2; pc_sel = 2'd2;
    @(negedge clk);
    chk("R2", "idle out_valid", {15'd0, out_valid}, 16'd0);
    chk("R2", "hold alu_b", alu_b, last_exp.b);
    chk("R2", "hold eff_addr", eff_addr, last_exp.ea);
    chk("R2", "hold addr_sum", addr_sum, last_exp.sum);
    chk("R2", "hold next_pc", next_pc, last_exp.npc);
  endtask

  // monitor: pops one expected item per valid result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R2 unexpected out_valid: actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        last_exp = e;
        chk(e.tag, "alu_b", alu_b, e.b);
        chk(e.tag, "eff_addr", eff_addr, e.ea);
        chk(e.tag, "addr_sum", addr_sum, e.sum);
        chk(e.tag, "next_pc", next_pc, e.npc);
      end
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; ifield = 11'h7FF; pc_inc = 16'hFFFF;
    base_val = 16'hFFFF; sr2_val = 16'hFFFF; bus_val = 16'hFFFF;
    base_sel = 2'd0; ofs_sel = 2'd3; mar_sel = 2'd0; pc_sel = 2'd1;
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1", "reset alu_b", alu_b, 16'd0);
    chk("R1", "reset eff_addr", eff_addr, 16'd0);
    chk("R1", "reset addr_sum", addr_sum, 16'd0);
    chk("R1", "reset next_pc", next_pc, 16'd0);
    rst = 1'b0; in_valid = 1'b0;

    // R3 register mode and immediate mode (+5, -16, -1)
    drive("R3", 16'h14C2, 16'h3001, 16'h0000, 16'hA5A5, 16'h0, 2'd0, 2'd0, 2'd0, 2'd0);
    drive("R3", 16'h14A5, 16'h3002, 16'h0000, 16'hA5A5, 16'h0, 2'd0, 2'd0, 2'd0, 2'd0);
    drive("R3", 16'h1430, 16'h3003, 16'h0000, 16'h1111, 16'h0, 2'd0, 2'd0, 2'd0, 2'd0);
    drive("R3", 16'h143F, 16'h3004, 16'h0000, 16'h1111, 16'h0, 2'd0, 2'd0, 2'd0, 2'd0);
    // R4 R6 PC-relative load-effective-address: pc 30F7 + (-3) = 30F4
    drive("R4", 16'hE3FD, 16'h30F7, 16'h0, 16'h0, 16'h0, 2'd0, 2'd2, 2'd0, 2'd0);
    // R4 extreme 9-bit offsets +255 and -256
    drive("R4", 16'h00FF, 16'h8000, 16'h0, 16'h0, 16'h0, 2'd0, 2'd2, 2'd0, 2'd1);
    drive("R4", 16'h0100, 16'h8000, 16'h0, 16'h0, 16'h0, 2'd0, 2'd2, 2'd3, 2'd1);
    // R4 R5 base+offset with 6-bit offset, and 11-bit offset on PC
    drive("R5", 16'h6A4E, 16'h3010, 16'h3100, 16'h0, 16'h0, 2'd1, 2'd1, 2'd0, 2'd0);
    drive("R4", 16'h4C00, 16'h4000, 16'h0, 16'h0, 16'h0, 2'd0, 2'd3, 2'd0, 2'd1);
    drive("R4", 16'h43FF, 16'h4000, 16'h0, 16'h0, 16'h0, 2'd0, 2'd3, 2'd0, 2'd1);
    // R5 zero base with both encodings
    drive("R5", 16'h0123, 16'h7777, 16'h5555, 16'h0, 16'h0, 2'd2, 2'd2, 2'd0, 2'd3);
    drive("R5", 16'h003F, 16'h7777, 16'h5555, 16'h0, 16'h0, 2'd3, 2'd1, 2'd0, 2'd0);
    // R6 wraparound at top and bottom
    drive("R6", 16'h0005, 16'hFFFF, 16'h0, 16'h0, 16'h0, 2'd0, 2'd2, 2'd0, 2'd1);
    drive("R6", 16'h003F, 16'h0001, 16'h0000, 16'h0, 16'h0, 2'd1, 2'd1, 2'd0, 2'd1);
    // R7 trap vector zero-extended, and indirect from bus
    drive("R7", 16'hF0A5, 16'h3011, 16'h0, 16'h0, 16'hBEEF, 2'd0, 2'd0, 2'd1, 2'd0);
    drive("R7", 16'hA7F7, 16'h30FD, 16'h0, 16'h0, 16'h3102, 2'd0, 2'd2, 2'd2, 2'd0);
    // R8 next PC from bus
    drive("R8", 16'h0000, 16'h1234, 16'h0, 16'h0, 16'h0400, 2'd0, 2'd0, 2'd0, 2'd2);
    idle_scramble();
    // R9 register jumps to the extremes
    drive("R9", 16'hC0C0, 16'h3005, 16'hFFFF, 16'h0, 16'h0, 2'd1, 2'd0, 2'd0, 2'd1);
    drive("R9", 16'hC0C0, 16'h3006, 16'h0000, 16'h0, 16'h0, 2'd1, 2'd0, 2'd0, 2'd1);
    drive("R9", 16'hC0C0, 16'h3007, 16'hBEEF, 16'h0, 16'h0, 2'd1, 2'd0, 2'd0, 2'd1);
    idle_scramble();
    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R2 missing results: actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule